// File: doc/BRIEF.md
# Serial Port Register Bank

This block is the register side of a simple serial port. A host reaches it through a 32-bit, word-addressed bus. It keeps a receive queue of bytes that the host can inspect in two ways. One read leaves the head byte in place. The other read takes the head byte off the queue. Bytes from the line side arrive on a valid/ready byte stream. Bytes the host writes for transmission leave on a second byte stream.

A small interrupt unit collects three event sources: receive data waiting, and two transmit events raised by each transmit write. It keeps a raw event word, a mask and an acknowledge register, and drives one level interrupt line. All other words in the register window are plain read/write storage for line settings that are decoded elsewhere.

A transmit write is held with the bus ready signal until the transmit stream takes the byte.

Top module: `uart_reg_bank`

## Requirements
- R1: After reset, the receive control word (offset 0x08) reads 0x00010000 and the raw event word (0x34) reads 0. The interrupt line is low, and `rx_ready` is low.
- R2: A read at offset 0x24 returns a status word, with the head byte in bits 7:0, bit 16 set when the queue holds data, and bits 22 and 24 always set. The queue is left unchanged.
- R3: A read at offset 0x20 returns the same status word and removes the head byte when the queue is not empty. When the queue is empty, the read changes nothing.
- R4: The queue holds 16 bytes and returns them in arrival order, including across pointer wrap-around. A byte offered while the queue already holds 16 is consumed and discarded.
- R5: `rx_ready` equals bit 3 of the receive control word. While that bit is 0, offered bytes are not taken.
- R6: A write to offset 0x1C presents the low byte of the write data on the transmit stream and stores the whole word for read-back. It also sets raw event bits 0 and 1.
- R7: While `tx_ready` is low, a write to offset 0x1C keeps `bus_ack` low and is not performed. It completes in the cycle in which `tx_ready` is high.
- R8: A write to offset 0x30 clears every raw event bit that is 1 in the written value. On the first such write after a transmit, bit 0 of the value is treated as 0. The value actually applied can be read back at 0x30.
- R9: Raw event bit 3 is 1 exactly while the queue holds data, and an acknowledge cannot clear it.
- R10: The word at 0x38 reads raw AND mask, with the mask at 0x2C. The interrupt line is high exactly while that word is non-zero.
- R11: Other word offsets below 0x3C read back what was last written. Offsets 0x3C and above read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ack is high |
| bus_ack | output | 1 | Access completes at the next clock edge |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Receiver enabled |
| tx_valid | output | 1 | Transmit byte offered |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmit sink takes the byte |
| irq | output | 1 | Level interrupt |

## Verification
The checks assume that the host issues at most one access per cycle and holds it steady, request included, until `bus_ack` rises. They also assume that a request carries no unknown address bits. The directed tasks meet these assumptions by driving every access on the falling edge and keeping it until the acknowledge has been seen at a rising edge. Receive bytes are offered for one cycle at a time on separate falling edges, so each case of queue full, pop and simultaneous arrival is set up on purpose rather than by chance.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;

    localparam int DATA_W    = 32;
    localparam int BYTE_W    = 8;
    localparam int WORD_W    = 4;
    localparam int NUM_WORDS = 15;
    localparam int NUM_SLOTS = 1 << WORD_W;

    // word indices (byte offset / 4)
    localparam logic [WORD_W-1:0] W_RXCTRL = 4'd2;
    localparam logic [WORD_W-1:0] W_DOUT   = 4'd7;
    localparam logic [WORD_W-1:0] W_POP    = 4'd8;
    localparam logic [WORD_W-1:0] W_PEEK   = 4'd9;
    localparam logic [WORD_W-1:0] W_MASK   = 4'd11;
    localparam logic [WORD_W-1:0] W_ACK    = 4'd12;
    localparam logic [WORD_W-1:0] W_RAW    = 4'd13;
    localparam logic [WORD_W-1:0] W_MASKED = 4'd14;

    localparam int RXEN_BIT   = 3;
    localparam int AVAIL_BIT  = 16;
    localparam int IDLE_BIT   = 22;
    localparam int RDY_BIT    = 24;
    localparam int EV_RX_BIT  = 3;

    localparam logic [DATA_W-1:0] RXCTRL_RST = 32'h0001_0000;

    typedef struct packed {
        logic              in_win;
        logic [WORD_W-1:0] word;
        logic              wr_plain;
        logic              wr_ack;
        logic              wr_raw;
        logic              tx_fire;
        logic              rd_pop;
    } dec_t;

    function automatic logic [DATA_W-1:0] status_word(input logic [BYTE_W-1:0] head,
                                                      input logic avail);
        logic [DATA_W-1:0] w;
        w = '0;
        w[BYTE_W-1:0] = head;
        w[AVAIL_BIT]  = avail;
        w[IDLE_BIT]   = 1'b1;
        w[RDY_BIT]    = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/uart_reg_decode.sv
module uart_reg_decode
    import uart_reg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              tx_ready,
    output logic              bus_ack,
    output dec_t              dec
);
    localparam int IDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

    logic [IDX_W-1:0] idx;
    logic             is_dout;
    logic             wr_go;

    always_comb begin
        idx     = bus_addr[ADDR_W-1:2];
        dec     = '0;
        dec.in_win = (idx <= LAST_IDX);
        dec.word   = idx[WORD_W-1:0];
        is_dout = dec.in_win && (dec.word == W_DOUT);
        bus_ack = bus_req && !(bus_we && is_dout && !tx_ready);
        wr_go   = bus_ack && bus_we && dec.in_win;
        dec.tx_fire  = wr_go && is_dout;
        dec.wr_ack   = wr_go && (dec.word == W_ACK);
        dec.wr_raw   = wr_go && (dec.word == W_RAW);
        dec.wr_plain = wr_go && (dec.word != W_ACK) && (dec.word != W_RAW);
        dec.rd_pop   = bus_ack && !bus_we && dec.in_win && (dec.word == W_POP);
    end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             store, take;

    assign store = push && (count != CNT_FULL);
    assign take  = pop && (count != '0);
    assign head  = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (store) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (store) wr_ptr <= bump(wr_ptr);
            if (take)  rd_ptr <= bump(rd_ptr);
            case ({store, take})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_fire,
    input  logic              wr_ack,
    input  logic              wr_raw,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rx_avail,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] raw_view,
    output logic [DATA_W-1:0] masked,
    output logic [DATA_W-1:0] ack_q,
    output logic              irq
);
    logic [DATA_W-1:0] raw_q;
    logic              tx_pend_q;
    logic [DATA_W-1:0] ack_eff;

    always_comb begin
        ack_eff = wdata;
        if (tx_pend_q) ack_eff[0] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q     <= '0;
            tx_pend_q <= 1'b0;
            ack_q     <= '0;
        end else if (tx_fire) begin
            raw_q     <= raw_q | 32'h3;
            tx_pend_q <= 1'b1;
        end else if (wr_ack) begin
            raw_q     <= raw_q & ~ack_eff & ~(32'h1 << EV_RX_BIT);
            ack_q     <= ack_eff;
            tx_pend_q <= 1'b0;
        end else if (wr_raw) begin
            raw_q     <= wdata & ~(32'h1 << EV_RX_BIT);
        end
    end

    always_comb begin
        raw_view            = raw_q;
        raw_view[EV_RX_BIT] = rx_avail;
        masked              = raw_view & mask;
        irq                 = |masked;
    end
endmodule

// File: rtl/uart_reg_bank.sv
module uart_reg_bank
    import uart_reg_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ack,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    output logic              irq
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    dec_t              dec;
    logic [DATA_W-1:0] slot_q [NUM_SLOTS];
    logic [BYTE_W-1:0] rx_head;
    logic [CNT_W-1:0]  rx_count;
    logic              rx_pop;
    logic              rx_avail;
    logic [DATA_W-1:0] irq_raw, irq_masked, ack_q;

    uart_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_req  (bus_req),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .tx_ready (tx_ready),
        .bus_ack  (bus_ack),
        .dec      (dec)
    );

    // plain storage slots, one per word index
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        localparam logic [DATA_W-1:0] RST_VAL =
            (s == int'(W_RXCTRL)) ? RXCTRL_RST : '0;
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[s] <= RST_VAL;
            else if (dec.wr_plain && dec.word == WORD_W'(s))
                slot_q[s] <= bus_wdata;
        end
    end

    assign rx_ready = slot_q[W_RXCTRL][RXEN_BIT];
    assign rx_pop   = dec.rd_pop;
    assign rx_avail = (rx_count != '0);

    uart_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (rx_valid && rx_ready),
        .push_data (rx_data),
        .pop       (rx_pop),
        .head      (rx_head),
        .count     (rx_count)
    );

    uart_irq_ctrl u_irq (
        .clk      (clk),
        .rst      (rst),
        .tx_fire  (dec.tx_fire),
        .wr_ack   (dec.wr_ack),
        .wr_raw   (dec.wr_raw),
        .wdata    (bus_wdata),
        .rx_avail (rx_avail),
        .mask     (slot_q[W_MASK]),
        .raw_view (irq_raw),
        .masked   (irq_masked),
        .ack_q    (ack_q),
        .irq      (irq)
    );

    assign tx_valid = bus_req && bus_we && dec.in_win && (dec.word == W_DOUT);
    assign tx_data  = bus_wdata[BYTE_W-1:0];

    always_comb begin
        bus_rdata = '0;
        if (dec.in_win) begin
            case (dec.word)
                W_POP, W_PEEK: bus_rdata = status_word(rx_head, rx_avail);
                W_RAW:         bus_rdata = irq_raw;
                W_MASKED:      bus_rdata = irq_masked;
                W_ACK:         bus_rdata = ack_q;
                default:       bus_rdata = slot_q[dec.word];
            endcase
        end
    end
endmodule

// File: rtl/uart_reg_bank_chk.sv
module uart_reg_bank_chk #(
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              bus_ack,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              tx_ready,
    input logic              irq,
    input logic [CNT_W-1:0]  rx_count,
    input logic              rx_pop,
    input logic [31:0]       irq_raw,
    input logic [31:0]       mask_word
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [ADDR_W-3:0] widx;
    assign widx = bus_addr[ADDR_W-1:2];

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        rx_count <= FULL);

    assert_drop_full_R4: assert property (@(posedge clk) disable iff (rst)
        (rx_count == FULL && rx_valid && rx_ready && !rx_pop) |=> rx_count == FULL);

    assert_peek_keeps_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we && widx == (ADDR_W-2)'(9) && !(rx_valid && rx_ready))
        |=> $stable(rx_count));

    assert_status_bits_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we && widx == (ADDR_W-2)'(8)) |-> (bus_rdata[24] && bus_rdata[22]));

    assert_tx_wait_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && widx == (ADDR_W-2)'(7) && !tx_ready) |-> !bus_ack);

    assert_tx_event_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_ack && widx == (ADDR_W-2)'(7)) |=> (irq_raw[1:0] == 2'b11));

    assert_rx_event_R9: assert property (@(posedge clk) disable iff (rst)
        irq_raw[3] == (rx_count != '0));

    assert_irq_level_R10: assert property (@(posedge clk) disable iff (rst)
        ((rx_count != '0) && mask_word[3]) |-> irq);
endmodule

bind uart_reg_bank uart_reg_bank_chk #(
    .ADDR_W (ADDR_W),
    .DEPTH  (FIFO_DEPTH),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .bus_ack   (bus_ack),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .tx_ready  (tx_ready),
    .irq       (irq),
    .rx_count  (rx_count),
    .rx_pop    (rx_pop),
    .irq_raw   (irq_raw),
    .mask_word (slot_q[11])
);

// File: tb/uart_reg_bank_test.sv
module uart_reg_bank_test;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_req = 1'b0, bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_ack;
    logic              rx_valid = 1'b0;
    logic [7:0]        rx_data = '0;
    logic              rx_ready;
    logic              tx_valid;
    logic [7:0]        tx_data;
    logic              tx_ready = 1'b1;
    logic              irq;

    int checks = 0;
    int errors = 0;
    int tx_cnt = 0;
    logic [7:0] tx_last = '0;

    always #2 clk = ~clk;

    uart_reg_bank #(.ADDR_W(ADDR_W), .FIFO_DEPTH(16)) uut (
        .clk(clk), .rst(rst),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .irq(irq)
    );

    always @(posedge clk) begin
        if (tx_valid && tx_ready) begin
            tx_last <= tx_data;
            tx_cnt  <= tx_cnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        #1;
        while (!bus_ack) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        while (!bus_ack) begin @(negedge clk); #1; end
        d = bus_rdata;
        @(posedge clk); #1;
        bus_req = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(8'h08, v); chk("R1 rxctrl", v, 32'h0001_0000);
        rd(8'h34, v); chk("R1 raw", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 rx_ready", {31'b0, rx_ready}, 32'h0);
    endtask

    task automatic t_peek_pop;
        logic [31:0] v;
        wr(8'h08, 32'h0001_0008);
        #1 chk("R5 rx_ready on", {31'b0, rx_ready}, 32'h1);
        rd(8'h24, v); chk("R2 empty status", v & 32'hFFFF_0000, 32'h0140_0000);
        push(8'hA1); push(8'hB2); push(8'hC3);
        rd(8'h24, v); chk("R2 peek", v, 32'h0141_00A1);
        rd(8'h24, v); chk("R2 peek again", v, 32'h0141_00A1);
        rd(8'h34, v); chk("R9 raw rx bit", v, 32'h8);
        rd(8'h20, v); chk("R3 pop 1", v, 32'h0141_00A1);
        rd(8'h20, v); chk("R3 pop 2", v, 32'h0141_00B2);
        rd(8'h24, v); chk("R3 head after pops", v, 32'h0141_00C3);
        rd(8'h20, v); chk("R3 pop 3", v, 32'h0141_00C3);
        rd(8'h20, v); chk("R3 empty pop", v & 32'hFFFF_0000, 32'h0140_0000);
        rd(8'h34, v); chk("R9 raw cleared", v, 32'h0);
    endtask

    task automatic t_full;
        logic [31:0] v;
        for (int i = 0; i < 17; i++) push(8'(8'h10 + i));
        for (int i = 0; i < 16; i++) begin
            rd(8'h20, v);
            chk("R4 order", v, 32'h0141_0000 | 32'(8'h10 + i));
        end
        rd(8'h24, v); chk("R4 overflow dropped", v & 32'hFFFF_0000, 32'h0140_0000);
    endtask

    task automatic t_disabled;
        logic [31:0] v;
        wr(8'h08, 32'h0001_0000);
        #1 chk("R5 rx_ready off", {31'b0, rx_ready}, 32'h0);
        push(8'h77);
        rd(8'h24, v); chk("R5 byte ignored", v & 32'hFFFF_0000, 32'h0140_0000);
        wr(8'h08, 32'h0001_0008);
    endtask

    task automatic t_mask;
        logic [31:0] v;
        wr(8'h2C, 32'h8);
        push(8'h5A);
        #1 chk("R10 irq on", {31'b0, irq}, 32'h1);
        rd(8'h38, v); chk("R10 masked", v, 32'h8);
        wr(8'h30, 32'hF);
        rd(8'h34, v); chk("R9 ack cannot clear", v, 32'h8);
        wr(8'h2C, 32'h0);
        #1 chk("R10 irq masked off", {31'b0, irq}, 32'h0);
        rd(8'h20, v); chk("R3 pop 5A", v, 32'h0141_005A);
    endtask

    task automatic t_tx;
        logic [31:0] v;
        int n;
        wr(8'h2C, 32'h3);
        n = tx_cnt;
        wr(8'h1C, 32'h1234_5655);
        #1 chk("R6 tx count", 32'(tx_cnt), 32'(n + 1));
        chk("R6 tx byte", {24'b0, tx_last}, 32'h55);
        rd(8'h34, v); chk("R6 raw", v, 32'h3);
        rd(8'h1C, v); chk("R6 dout readback", v, 32'h1234_5655);
        chk("R10 irq tx", {31'b0, irq}, 32'h1);
        rd(8'h38, v); chk("R10 masked tx", v, 32'h3);
        wr(8'h30, 32'h3);
        rd(8'h34, v); chk("R8 first ack keeps bit0", v, 32'h1);
        rd(8'h30, v); chk("R8 applied ack", v, 32'h2);
        wr(8'h30, 32'h1);
        rd(8'h34, v); chk("R8 second ack", v, 32'h0);
        chk("R10 irq clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_wait;
        int n;
        n = tx_cnt;
        tx_ready = 1'b0;
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 8'h1C; bus_wdata = 32'h0000_00E7;
        repeat (3) begin
            #1 chk("R7 ack held", {31'b0, bus_ack}, 32'h0);
            @(negedge clk);
        end
        chk("R7 no byte sent", 32'(tx_cnt), 32'(n));
        tx_ready = 1'b1;
        #1 chk("R7 ack released", {31'b0, bus_ack}, 32'h1);
        @(posedge clk); #1;
        bus_req = 1'b0; bus_we = 1'b0;
        chk("R7 byte sent", 32'(tx_cnt), 32'(n + 1));
        chk("R7 byte value", {24'b0, tx_last}, 32'hE7);
        wr(8'h30, 32'h3);
    endtask

    task automatic t_plain;
        logic [31:0] v;
        wr(8'h0C, 32'hDEAD_BEEF);
        rd(8'h0C, v); chk("R11 plain 0C", v, 32'hDEAD_BEEF);
        wr(8'h00, 32'h0000_00A5);
        rd(8'h00, v); chk("R11 plain 00", v, 32'h0000_00A5);
        wr(8'h3C, 32'hFFFF_FFFF);
        rd(8'h3C, v); chk("R11 outside reads 0", v, 32'h0);
        rd(8'h0C, v); chk("R11 outside write no effect", v, 32'hDEAD_BEEF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset;
        t_peek_pop;
        t_full;
        t_disabled;
        t_mask;
        t_tx;
        t_wait;
        t_plain;
        repeat (2) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule